// File: doc/BRIEF.md
# Between-Class Variance Unit (Division-Free)

This block evaluates the between-class variance of a two-class intensity split for one candidate threshold. It takes the cumulative class probability `omega`, the cumulative first moment `mu` and the image-wide mean `mg`. It returns `(mg*omega - mu)^2 / (omega*(1 - omega))` as a signed fixed-point number. A threshold search replicates the unit once per grey level and compares the outputs in a maximum tree. That replication is outside this block.

The numerator and denominator are built side by side. The numerator path takes the product `omega*mg`, subtracts `mu` and squares the difference. The denominator path forms `1 - omega` and multiplies it by `omega`. No divider is used. The denominator's binary point is moved eight places to the right, and the resulting integer part selects a reciprocal from a 256-word table. One multiplication by that word completes the quotient. A valid flag travels with the data. The unit accepts a new operand set on every clock.

Top module: `bcv_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid` is 0 and `out_var` is 0. A reset asserted while operands are in flight discards them, and none of them reaches `out_valid`.
- R2: Each operand set sampled with `in_valid` high produces exactly one `out_valid` pulse, four clock edges later. Operand sets presented on consecutive cycles come out on consecutive cycles, in order.
- R3: The numerator is computed in three steps. First, `omega*mg` (unsigned, 24 fraction bits times 8.24) is truncated to unsigned 8.24. Second, `mu` is subtracted to give a signed 9.24 difference. Third, that difference is squared and truncated to signed 18.24.
- R4: The denominator is computed in two steps. First, `1 - omega` is formed modulo 2^24, so `omega = 0` gives 0. Second, it is multiplied by `omega` and truncated to 24 fraction bits.
- R5: The reciprocal address is the denominator's top 8 fraction bits (bits 23..16). Entry `a` of the table holds `min(floor(2^32 / a), 2^32 - 1)` as signed 9.24, and entry 0 holds 0.
- R6: `out_var` is the 18.24 numerator times the 9.24 reciprocal, truncated to signed 27.24 (51 bits).
- R7: An operand set with `omega = 0`, or one whose denominator address is 0 (for example `omega = 0xFFFFFF`), gives `out_var = 0`.
- R8: On a cycle without `out_valid`, `out_var` keeps its previous value. Operand values presented with `in_valid` low produce no output.
- R9: Every valid `out_var` is non-negative (bit 50 is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set present this cycle |
| in_omega | input | 24 | Class probability, unsigned 0.24 |
| in_mu | input | 32 | Cumulative first moment, unsigned 8.24 |
| in_mg | input | 32 | Global mean, unsigned 8.24 |
| out_valid | output | 1 | Result present this cycle |
| out_var | output | 51 | Between-class variance, signed 27.24 |

## Verification
The bench builds the unit with its default widths: 8 integer bits for means, 24 fraction bits and a 256-word table. At these widths every truncation point is exercised. The table's zero entry is reached through several routes: `omega` at 0, `omega` just below one, and a small `omega` whose denominator stays below 1/256. A `omega` of 2^-7 reaches the saturated entry 1. A negative difference from `mu` above the scaled mean shows that squaring removes the sign. A mid-flight reset and idle cycles carrying garbage operands show that the valid chain alone decides which results appear.

// File: rtl/bcv_pkg.sv
package bcv_pkg;

  localparam int FRAC_W   = 24;
  localparam int PIX_W    = 8;
  localparam int ADDR_W   = PIX_W;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int MEAN_W   = PIX_W + FRAC_W;
  localparam int DIFF_W   = MEAN_W + 1;
  localparam int NUM_W    = 2 * (PIX_W + 1) + FRAC_W;
  localparam int RCP_W    = PIX_W + 1 + FRAC_W;
  localparam int VAR_W    = NUM_W + RCP_W - FRAC_W;
  localparam int PIPE_LAT = 4;
  localparam longint unsigned RCP_MAX = (64'd1 << (RCP_W - 1)) - 64'd1;

  typedef logic        [FRAC_W-1:0] frac_t;
  typedef logic        [MEAN_W-1:0] mean_t;
  typedef logic signed [DIFF_W-1:0] diff_t;
  typedef logic signed [NUM_W-1:0]  num_t;
  typedef logic signed [RCP_W-1:0]  rcp_t;
  typedef logic signed [VAR_W-1:0]  var_t;
  typedef logic        [ADDR_W-1:0] addr_t;

  // omega (0.FRAC) times a mean (PIX.FRAC), kept as PIX.FRAC
  function automatic mean_t scale_mean(frac_t om, mean_t m);
    logic [FRAC_W+MEAN_W-1:0] full;
    full = om * m;
    return full[FRAC_W +: MEAN_W];
  endfunction

  // 1.0 - omega, wrapping modulo one unit
  function automatic frac_t complement(frac_t om);
    return frac_t'(0) - om;
  endfunction

  // product of two pure fractions, kept to FRAC_W bits
  function automatic frac_t spread(frac_t a, frac_t b);
    logic [2*FRAC_W-1:0] full;
    full = a * b;
    return full[FRAC_W +: FRAC_W];
  endfunction

  // signed gap between two unsigned means
  function automatic diff_t offset(mean_t p, mean_t q);
    return $signed({1'b0, p}) - $signed({1'b0, q});
  endfunction

  // squared gap, kept to FRAC_W fraction bits
  function automatic num_t square(diff_t d);
    logic signed [2*DIFF_W-1:0] full;
    full = d * d;
    return full[FRAC_W +: NUM_W];
  endfunction

  // reciprocal word for table index a: 2^ADDR_W / (a / 2^ADDR_W) scale
  function automatic rcp_t recip_word(int a);
    longint unsigned q;
    if (a == 0) return '0;
    q = (64'd1 << (FRAC_W + ADDR_W)) / longint'(a);
    if (q > RCP_MAX) q = RCP_MAX;
    return rcp_t'(q);
  endfunction

  // numerator times reciprocal, kept to FRAC_W fraction bits
  function automatic var_t weigh(num_t n, rcp_t r);
    logic signed [NUM_W+RCP_W-1:0] full;
    full = n * r;
    return full[FRAC_W +: VAR_W];
  endfunction

endpackage

// File: rtl/bcv_numer.sv
module bcv_numer
  import bcv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] stg_en,
  input  frac_t      omega,
  input  mean_t      mu,
  input  mean_t      mg,
  output num_t       num_q
);

  mean_t prod_q;
  mean_t mu_q;
  diff_t gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      mu_q   <= '0;
      gap_q  <= '0;
      num_q  <= '0;
    end else begin
      if (stg_en[0]) begin
        prod_q <= scale_mean(omega, mg);
        mu_q   <= mu;
      end
      if (stg_en[1]) gap_q <= offset(prod_q, mu_q);
      if (stg_en[2]) num_q <= square(gap_q);
    end
  end

endmodule

// File: rtl/bcv_denom.sv
module bcv_denom
  import bcv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] stg_en,
  input  frac_t      omega,
  output addr_t      addr_q
);

  frac_t om_q;
  frac_t rest_q;
  frac_t den_w;

  // point shift: the top ADDR_W fraction bits become the table index
  assign den_w = spread(om_q, rest_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      om_q   <= '0;
      rest_q <= '0;
      addr_q <= '0;
    end else begin
      if (stg_en[0]) begin
        om_q   <= omega;
        rest_q <= complement(omega);
      end
      if (stg_en[1]) addr_q <= den_w[FRAC_W-1 -: ADDR_W];
    end
  end

endmodule

// File: rtl/bcv_recip_rom.sv
module bcv_recip_rom
  import bcv_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  rd_en,
  input  addr_t addr,
  output rcp_t  word_q
);

  rcp_t table_w [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_ent
    assign table_w[a] = recip_word(a);
  end

  always_ff @(posedge clk) begin
    if (rst)        word_q <= '0;
    else if (rd_en) word_q <= table_w[addr];
  end

endmodule

// File: rtl/bcv_scale.sv
module bcv_scale
  import bcv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  num_t num,
  input  rcp_t rcp,
  output var_t var_q
);

  always_ff @(posedge clk) begin
    if (rst)     var_q <= '0;
    else if (en) var_q <= weigh(num, rcp);
  end

endmodule

// File: rtl/bcv_unit.sv
module bcv_unit
  import bcv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [FRAC_W-1:0] in_omega,
  input  logic [MEAN_W-1:0] in_mu,
  input  logic [MEAN_W-1:0] in_mg,
  output logic              out_valid,
  output logic [VAR_W-1:0]  out_var
);

  // valid chain: bit i is the flag of pipeline stage i+1
  logic [PIPE_LAT-1:0] vld_q;
  num_t  num_q;
  addr_t tbl_addr;
  rcp_t  tbl_word;
  var_t  var_q;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[PIPE_LAT-2:0], in_valid};
  end

  bcv_numer u_numer (
    .clk    (clk),
    .rst    (rst),
    .stg_en ({vld_q[1], vld_q[0], in_valid}),
    .omega  (in_omega),
    .mu     (in_mu),
    .mg     (in_mg),
    .num_q  (num_q)
  );

  bcv_denom u_denom (
    .clk    (clk),
    .rst    (rst),
    .stg_en ({vld_q[0], in_valid}),
    .omega  (in_omega),
    .addr_q (tbl_addr)
  );

  bcv_recip_rom u_rom (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (vld_q[1]),
    .addr   (tbl_addr),
    .word_q (tbl_word)
  );

  bcv_scale u_scale (
    .clk   (clk),
    .rst   (rst),
    .en    (vld_q[2]),
    .num   (num_q),
    .rcp   (tbl_word),
    .var_q (var_q)
  );

  assign out_valid = vld_q[PIPE_LAT-1];
  assign out_var   = var_q;

endmodule

// File: rtl/bcv_unit_chk.sv
module bcv_unit_chk
  import bcv_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  in_valid,
  input frac_t in_omega,
  input logic  out_valid,
  input var_t  out_var,
  input logic  stg2_valid,
  input addr_t tbl_addr,
  input rcp_t  tbl_word
);

  // edges seen since reset, saturating at the pipeline depth
  logic [2:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)                        age_q <= '0;
    else if (age_q != 3'(PIPE_LAT)) age_q <= age_q + 3'd1;
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    (age_q == 3'(PIPE_LAT)) |-> (out_valid == $past(in_valid, 4)));

  a_r5_entry_zero: assert property (@(posedge clk) disable iff (rst)
    (stg2_valid && tbl_addr == '0) |=> (tbl_word == '0));

  a_r5_entry_sat: assert property (@(posedge clk) disable iff (rst)
    (stg2_valid && tbl_addr == addr_t'(1)) |=> (tbl_word == rcp_t'(RCP_MAX)));

  a_r7_zero_omega: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_omega == '0) |-> ##4 (out_valid && out_var == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (age_q != 3'd0 && !out_valid) |-> $stable(out_var));

  a_r9_nonneg: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_var[VAR_W-1]);

endmodule

bind bcv_unit bcv_unit_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_omega   (in_omega),
  .out_valid  (out_valid),
  .out_var    (out_var),
  .stg2_valid (vld_q[1]),
  .tbl_addr   (tbl_addr),
  .tbl_word   (tbl_word)
);

// File: tb/bcv_unit_tb.sv
module bcv_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [23:0] om;
    logic [31:0] mu;
    logic [31:0] mg;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{24'h800000, 32'h00000000, 32'h80000000},
    '{24'h000000, 32'h10000000, 32'h40000000},
    '{24'hFFFFFF, 32'h7F000000, 32'h7F800000},
    '{24'h020000, 32'h00000000, 32'hFF000000},
    '{24'h400000, 32'h20000000, 32'h64000000},
    '{24'h123456, 32'h01234567, 32'h89ABCDEF},
    '{24'hC00000, 32'h90000000, 32'h70000000},
    '{24'h010000, 32'h00400000, 32'h80000000},
    '{24'h7FFFFF, 32'h3FFFFF00, 32'hFFFFFFFF},
    '{24'hABCDEF, 32'hFEDCBA98, 32'h10000000},
    '{24'h333333, 32'h0A000000, 32'h32000000},
    '{24'hF0F0F0, 32'hE0000000, 32'hEEEEEEEE}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [23:0] in_omega = '0;
  logic [31:0] in_mu = '0;
  logic [31:0] in_mg = '0;
  logic        out_valid;
  logic [50:0] out_var;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [50:0] exp_q [$];
  int          tag_q [$];
  logic [50:0] last_var = '0;

  bcv_unit dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_omega  (in_omega),
    .in_mu     (in_mu),
    .in_mg     (in_mg),
    .out_valid (out_valid),
    .out_var   (out_var)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // model restated with wide unsigned magnitudes
  function automatic logic [50:0] ref_var(logic [23:0] om, logic [31:0] mu, logic [31:0] mg);
    logic [127:0] p, mag, sq, rest, den, idx, rcp, v;
    p    = (128'(om) * 128'(mg)) >> 24;
    mag  = (p >= 128'(mu)) ? p - 128'(mu) : 128'(mu) - p;
    sq   = (mag * mag) >> 24;
    rest = (om == 24'd0) ? 128'd0 : (128'd1 << 24) - 128'(om);
    den  = (128'(om) * rest) >> 24;
    idx  = den >> 16;
    if (idx == 0) rcp = 128'd0;
    else begin
      rcp = (128'd1 << 32) / idx;
      if (rcp > 128'hFFFF_FFFF) rcp = 128'hFFFF_FFFF;
    end
    v = (sq * rcp) >> 24;
    return v[50:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send(input logic [23:0] om, input logic [31:0] mu, input logic [31:0] mg,
                      input logic [50:0] expv);
    @(negedge clk);
    in_valid = 1'b1;
    in_omega = om;
    in_mu    = mu;
    in_mg    = mg;
    exp_q.push_back(expv);
    tag_q.push_back(cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_omega = 24'($urandom);
      in_mu    = $urandom;
      in_mg    = $urandom;
    end
  endtask

  // output monitor: order, latency (R2), value (R3 R4 R6), sign (R9), hold (R8)
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 spurious out_valid", 64'(out_var), 64'd0);
        end else begin
          logic [50:0] e;
          int t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(cyc - t == 4, "R2 latency", 64'(cyc - t), 64'd4);
          chk(out_var == e, "R6 value", 64'(out_var), 64'(e));
          chk(out_var[50] == 1'b0, "R9 sign", 64'(out_var[50]), 64'd0);
        end
      end else if (out_var !== last_var) begin
        chk(1'b0, "R8 hold", 64'(out_var), 64'(last_var));
      end
    end
    last_var = out_var;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_var == '0, "R1 reset state", 64'(out_var), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_var == '0, "R1 first cycle after reset", 64'(out_var), 64'd0);

    // R3 R4 R5 R6: table of vectors streamed back-to-back (R2 throughput)
    foreach (VECS[i]) send(VECS[i].om, VECS[i].mu, VECS[i].mg,
                           ref_var(VECS[i].om, VECS[i].mu, VECS[i].mg));
    // R8: garbage operands with in_valid low
    idle(10);
    chk(exp_q.size() == 0, "R2 one result per input", 64'(exp_q.size()), 64'd0);

    // R2 R6: isolated vector, exact cycle, hand value 16384.0
    send(24'h800000, 32'h0, 32'h80000000, 51'h40_0000_0000);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (i < 4) chk(out_valid == 1'b0, "R2 not early", 64'(out_valid), 64'd0);
      else begin
        chk(out_valid == 1'b1, "R2 on time", 64'(out_valid), 64'd1);
        chk(out_var == 51'h40_0000_0000, "R6 hand value", 64'(out_var), 64'h40_0000_0000);
      end
    end
    idle(3);

    // R5: saturated entry 1, hand value
    send(24'h020000, 32'h0, 32'hFF000000, 51'd17045913596);
    idle(6);
    // R7: omega zero and omega just below one
    send(24'h000000, 32'h12345678, 32'hABCDEF01, 51'd0);
    idle(1);
    send(24'hFFFFFF, 32'h00000000, 32'hFF000000, 51'd0);
    // R4 R7: small omega whose denominator index is 0
    send(24'h010000, 32'h00000000, 32'hFF000000, 51'd0);
    idle(2);
    // R3: negative difference squared
    send(24'h400000, 32'hC0000000, 32'h40000000,
         ref_var(24'h400000, 32'hC0000000, 32'h40000000));
    idle(8);
    chk(exp_q.size() == 0, "R2 gapped stream drained", 64'(exp_q.size()), 64'd0);

    // R1: reset with operands in flight
    send(24'h555555, 32'h11111111, 32'h22222222, 51'd0);
    send(24'h666666, 32'h33333333, 32'h44444444, 51'd0);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    exp_q.delete();
    tag_q.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 in-flight discarded", 64'(out_valid), 64'd0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule